// File: doc/BRIEF.md
# UART Prioritized Interrupt Identifier

This block turns the interrupt conditions of a 16550-style serial port, extended with two flow-control sources, into a single 8-bit status word and one interrupt line. Seven conditions are ranked across six priority levels. The status word names only the most urgent pending condition. Software services that condition, reads the word again, and only then sees the next one down.

Most sources are levels that the surrounding logic raises and lowers with its own clear conditions. Two sources are held inside the block:
- The transmit-holding-empty flag is set by a pulse. It is cleared by loading the holding register, or by a read of the status word while it is the reported source.
- The Xoff / special-character flag is set by a detection pulse and holds until an Xon pulse arrives.

An enhanced-mode enable hides the two flow-control sources. A FIFO-mode flag appears in the top two bits of the word. The word is frozen while a read is in progress.

Top module: `uart_int_ident`

## Requirements
- R1: After reset the status word reads 8'h01 and the interrupt line is low.
- R2: Priority, highest first: line status error, receive data ready, receive time-out, transmit holding empty, modem status change, Xoff/special character, CTS/RTS change. Receive data ready beats receive time-out when both are asserted.
- R3: Bits 5:0 carry the code of the reported source: line status 000110, data ready 000100, time-out 001100, holding empty 000010, modem 000000, Xoff 010000, CTS/RTS 100000.
- R4: With nothing pending, bits 5:0 read 000001. Bit 0 is 0 whenever any source is reported.
- R5: Bits 7:6 read 11 when fifo_en is 1 and read 00 when it is 0.
- R6: With enh_en at 0, the Xoff and CTS/RTS sources are masked, so bits 5:4 read 00. Raising enh_en exposes them again, and the Xoff flag is not lost while masked.
- R7: A pulse on xoff_det sets the Xoff flag. It stays set through any number of cycles until a pulse on xon_rcvd. If both pulses arrive in the same cycle, the set wins.
- R8: The holding-empty flag is set by a pulse on thr_empty_set. It is cleared by thr_load, or by a read (rd_en high at a clock edge) while the word reports holding empty. A read that reports a different source leaves the flag set. A clear that coincides with a set wins.
- R9: While rd_en is high the status word does not change. It tracks the sources again from the first edge after rd_en falls.
- R10: irq_o is registered and equals the inverse of status bit 0 whenever no read was in progress at the previous edge. It reflects a pending condition two edges after a set pulse, or one edge after a level source rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO mode active |
| enh_en | input | 1 | Enhanced-function enable for the flow-control sources |
| lsr_err | input | 1 | Line status error pending (level) |
| rx_ready | input | 1 | Receive data ready (level) |
| rx_timeout | input | 1 | Receive time-out (level) |
| thr_empty_set | input | 1 | Holding register became empty (pulse) |
| thr_load | input | 1 | Holding register written (pulse, clears holding-empty flag) |
| msr_chg | input | 1 | Modem status change pending (level) |
| xoff_det | input | 1 | Xoff or special character detected (pulse) |
| xon_rcvd | input | 1 | Xon character received (pulse) |
| flow_chg | input | 1 | CTS/RTS change of state pending (level) |
| rd_en | input | 1 | Status word read strobe |
| isr_o | output | 8 | Status word |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest situation to reach is a read that lands while holding empty is reported, with a lower source also pending underneath it.

The stimulus arranges this directly:
1. Set the holding-empty flag and raise the modem source.
2. Read once. The modem code should then surface.
3. Repeat with holding empty masked by a higher source. The read must leave the flag intact, and holding empty must reappear once the higher source drops.

A second hard case is the Xoff flag held across a masked period. The enable is dropped and restored before the Xon pulse arrives.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int NUM_SRC = 7;
   localparam int CODE_W  = 6;

   typedef enum logic [2:0] {
      SRC_LSR  = 3'd0,
      SRC_RXD  = 3'd1,
      SRC_RXTO = 3'd2,
      SRC_THRE = 3'd3,
      SRC_MSR  = 3'd4,
      SRC_XOFF = 3'd5,
      SRC_FLOW = 3'd6
   } irq_src_e;

   localparam logic [CODE_W-1:0] CODE_IDLE = 6'b000001;

   // Identification code placed in the low bits of the status word.
   function automatic logic [CODE_W-1:0] src_code(input irq_src_e s);
      case (s)
         SRC_LSR:  src_code = 6'b000110;
         SRC_RXD:  src_code = 6'b000100;
         SRC_RXTO: src_code = 6'b001100;
         SRC_THRE: src_code = 6'b000010;
         SRC_MSR:  src_code = 6'b000000;
         SRC_XOFF: src_code = 6'b010000;
         SRC_FLOW: src_code = 6'b100000;
         default:  src_code = CODE_IDLE;
      endcase
   endfunction

   // Source occupying a priority rank (0 = most urgent).
   function automatic irq_src_e rank_src(input int r, input bit tmo_first);
      case (r)
         0:       rank_src = SRC_LSR;
         1:       rank_src = tmo_first ? SRC_RXTO : SRC_RXD;
         2:       rank_src = tmo_first ? SRC_RXD  : SRC_RXTO;
         3:       rank_src = SRC_THRE;
         4:       rank_src = SRC_MSR;
         5:       rank_src = SRC_XOFF;
         default: rank_src = SRC_FLOW;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_d;

   generate
      if (SET_WINS) begin : g_set_dom
         always_comb begin
            if (set_i)      flag_d = 1'b1;
            else if (clr_i) flag_d = 1'b0;
            else            flag_d = flag_o;
         end
      end else begin : g_clr_dom
         always_comb begin
            if (clr_i)      flag_d = 1'b0;
            else if (set_i) flag_d = 1'b1;
            else            flag_d = flag_o;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= 1'b0;
      else        flag_o <= flag_d;
   end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int N_SRC     = NUM_SRC,
   parameter bit TMO_FIRST = 1'b0,
   parameter int WORD_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  req_i,
   input  logic              enh_i,
   input  logic              fifo_i,
   output logic [N_SRC-1:0]  grant_o,
   output logic [WORD_W-1:0] word_o
);

   localparam int FIFO_W = WORD_W - CODE_W;

   initial begin
      if (N_SRC != NUM_SRC) $error("uart_irq_prio: N_SRC must equal %0d", NUM_SRC);
      if (WORD_W != CODE_W + 2) $error("uart_irq_prio: WORD_W must be %0d", CODE_W + 2);
   end

   logic [N_SRC-1:0] req_m;

   always_comb begin
      req_m = req_i;
      if (!enh_i) begin
         req_m[SRC_XOFF] = 1'b0;
         req_m[SRC_FLOW] = 1'b0;
      end
   end

   logic [CODE_W-1:0] code;

   always_comb begin
      grant_o = '0;
      code    = CODE_IDLE;
      for (int r = N_SRC - 1; r >= 0; r--) begin
         if (req_m[rank_src(r, TMO_FIRST)]) begin
            grant_o = '0;
            grant_o[rank_src(r, TMO_FIRST)] = 1'b1;
            code = src_code(rank_src(r, TMO_FIRST));
         end
      end
      word_o = {{FIFO_W{fifo_i}}, code};
   end

   assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   assert_masked_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !enh_i |-> word_o[5:4] == 2'b00);

   assert_idle_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_m == '0) |-> word_o[0]);

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
   parameter int                WORD_W    = 8,
   parameter logic [WORD_W-1:0] RST_WORD  = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] word_o,
   output logic              irq_o
);

   initial begin
      if (RST_WORD[0] != 1'b1) $error("uart_irq_status: reset word must show no pending source");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o <= RST_WORD;
         irq_o  <= 1'b0;
      end else begin
         irq_o <= ~word_i[0];
         if (!rd_i) word_o <= word_i;
      end
   end

   assert_frozen_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> $stable(word_o));

   assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> irq_o == !word_o[0]);

endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
   import uart_irq_pkg::*;
#(
   parameter bit TMO_FIRST = 1'b0,
   parameter int WORD_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              enh_en,
   input  logic              lsr_err,
   input  logic              rx_ready,
   input  logic              rx_timeout,
   input  logic              thr_empty_set,
   input  logic              thr_load,
   input  logic              msr_chg,
   input  logic              xoff_det,
   input  logic              xon_rcvd,
   input  logic              flow_chg,
   input  logic              rd_en,
   output logic [WORD_W-1:0] isr_o,
   output logic              irq_o
);

   localparam logic [WORD_W-1:0] RST_WORD = {{(WORD_W-1){1'b0}}, 1'b1};

   logic thre_q, xoff_q, thre_rd_clr;
   logic [NUM_SRC-1:0] req, grant;
   logic [WORD_W-1:0]  word_nxt;

   assign thre_rd_clr = rd_en && (isr_o[CODE_W-1:0] == src_code(SRC_THRE));

   uart_irq_flag #(.SET_WINS(1'b0)) u_thre (
      .clk(clk), .rst_n(rst_n), .set_i(thr_empty_set),
      .clr_i(thr_load | thre_rd_clr), .flag_o(thre_q));

   uart_irq_flag #(.SET_WINS(1'b1)) u_xoff (
      .clk(clk), .rst_n(rst_n), .set_i(xoff_det),
      .clr_i(xon_rcvd), .flag_o(xoff_q));

   always_comb begin
      req = '0;
      req[SRC_LSR]  = lsr_err;
      req[SRC_RXD]  = rx_ready;
      req[SRC_RXTO] = rx_timeout;
      req[SRC_THRE] = thre_q;
      req[SRC_MSR]  = msr_chg;
      req[SRC_XOFF] = xoff_q;
      req[SRC_FLOW] = flow_chg;
   end

   uart_irq_prio #(.N_SRC(NUM_SRC), .TMO_FIRST(TMO_FIRST), .WORD_W(WORD_W)) u_prio (
      .clk(clk), .rst_n(rst_n), .req_i(req), .enh_i(enh_en), .fifo_i(fifo_en),
      .grant_o(grant), .word_o(word_nxt));

   uart_irq_status #(.WORD_W(WORD_W), .RST_WORD(RST_WORD)) u_stat (
      .clk(clk), .rst_n(rst_n), .rd_i(rd_en), .word_i(word_nxt),
      .word_o(isr_o), .irq_o(irq_o));

   assert_xoff_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (xoff_q && !xon_rcvd) |=> xoff_q);

   assert_xoff_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      xoff_det |=> xoff_q);

   assert_thre_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && isr_o[CODE_W-1:0] == 6'b000010) |=> !thre_q);

   assert_thre_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (thre_q && !thr_load && !(rd_en && isr_o[CODE_W-1:0] == 6'b000010)) |=> thre_q);

endmodule

// File: tb/tb_uart_int_ident.sv
module tb_uart_int_ident;

   logic clk = 1'b0, rst_n = 1'b0;
   logic fifo_en = 0, enh_en = 0, lsr_err = 0, rx_ready = 0, rx_timeout = 0;
   logic thr_empty_set = 0, thr_load = 0, msr_chg = 0, xoff_det = 0, xon_rcvd = 0;
   logic flow_chg = 0, rd_en = 0;
   logic [7:0] isr_o;
   logic irq_o;
   int n_vec = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   uart_int_ident dut (.*);

   task automatic step(int n = 1);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic clear_all();
      lsr_err = 0; rx_ready = 0; rx_timeout = 0; msr_chg = 0; flow_chg = 0;
      thr_load = 1; xon_rcvd = 1; step(); thr_load = 0; xon_rcvd = 0; step(2);
   endtask

   task automatic pulse_thre();
      thr_empty_set = 1; step(); thr_empty_set = 0;
   endtask

   task automatic do_read();
      rd_en = 1; step(); rd_en = 0; step();
   endtask

   task automatic t_reset();
      chk("R1 word", isr_o, 8'h01);
      chk("R1 irq", {7'd0, irq_o}, 8'h00);
   endtask

   task automatic t_codes();
      enh_en = 1; fifo_en = 0;
      lsr_err = 1; step(); chk("R3 lsr", isr_o, 8'b00000110); chk("R10 irq", {7'd0, irq_o}, 8'h01); lsr_err = 0;
      rx_ready = 1; step(); chk("R3 rxd", isr_o, 8'b00000100); rx_ready = 0;
      rx_timeout = 1; step(); chk("R3 rxto", isr_o, 8'b00001100); rx_timeout = 0;
      msr_chg = 1; step(); chk("R3 msr", isr_o, 8'b00000000); chk("R4 bit0 pending", {7'd0, isr_o[0]}, 8'h00); msr_chg = 0;
      flow_chg = 1; step(); chk("R3 flow", isr_o, 8'b00100000); flow_chg = 0;
      pulse_thre(); step(); chk("R3 thre", isr_o, 8'b00000010);
      clear_all(); chk("R4 idle", isr_o, 8'h01); chk("R10 idle irq", {7'd0, irq_o}, 8'h00);
   endtask

   task automatic t_priority();
      enh_en = 1;
      flow_chg = 1; xoff_det = 1; step(); xoff_det = 0; msr_chg = 1; pulse_thre();
      rx_timeout = 1; rx_ready = 1; lsr_err = 1; step(2);
      chk("R2 lsr top", isr_o, 8'b00000110); lsr_err = 0; step();
      chk("R2 rxd over rxto", isr_o, 8'b00000100); rx_ready = 0; step();
      chk("R2 rxto", isr_o, 8'b00001100); rx_timeout = 0; step();
      chk("R2 thre", isr_o, 8'b00000010); thr_load = 1; step(); thr_load = 0; step();
      chk("R2 msr", isr_o, 8'b00000000); msr_chg = 0; step();
      chk("R2 xoff", isr_o, 8'b00010000); xon_rcvd = 1; step(); xon_rcvd = 0; step();
      chk("R2 flow", isr_o, 8'b00100000);
      clear_all();
   endtask

   task automatic t_fifo();
      fifo_en = 1; step(2); chk("R5 fifo idle", isr_o, 8'hC1);
      lsr_err = 1; step(); chk("R5 fifo lsr", isr_o, 8'hC6);
      fifo_en = 0; step(); chk("R5 nonfifo", isr_o, 8'h06);
      clear_all();
   endtask

   task automatic t_enh();
      enh_en = 0; xoff_det = 1; step(); xoff_det = 0; flow_chg = 1; step(2);
      chk("R6 masked", isr_o, 8'h01); chk("R6 masked irq", {7'd0, irq_o}, 8'h00);
      flow_chg = 0; enh_en = 1; step(2);
      chk("R6 xoff kept", isr_o, 8'b00010000);
      clear_all();
   endtask

   task automatic t_xoff();
      enh_en = 1; xoff_det = 1; step(); xoff_det = 0; step(20);
      chk("R7 hold", isr_o, 8'b00010000);
      xon_rcvd = 1; step(); xon_rcvd = 0; step();
      chk("R7 xon clears", isr_o, 8'h01);
      xoff_det = 1; xon_rcvd = 1; step(); xoff_det = 0; xon_rcvd = 0; step();
      chk("R7 set wins", isr_o, 8'b00010000);
      clear_all();
   endtask

   task automatic t_thre();
      pulse_thre(); msr_chg = 1; step(2);
      chk("R8 thre shown", isr_o, 8'b00000010);
      do_read(); chk("R8 read clears", isr_o, 8'b00000000);
      msr_chg = 0; step(); chk("R8 stays clear", isr_o, 8'h01);
      pulse_thre(); lsr_err = 1; step(2);
      do_read(); lsr_err = 0; step(2);
      chk("R8 other read keeps", isr_o, 8'b00000010);
      thr_load = 1; thr_empty_set = 1; step(); thr_load = 0; thr_empty_set = 0; step();
      chk("R8 clear wins", isr_o, 8'h01);
      clear_all();
   endtask

   task automatic t_freeze();
      rd_en = 1; step(); lsr_err = 1; step(3);
      chk("R9 frozen", isr_o, 8'h01);
      rd_en = 0; step(); chk("R9 resumes", isr_o, 8'h06);
      chk("R10 irq", {7'd0, irq_o}, 8'h01);
      clear_all();
   endtask

   initial begin
      step(3); rst_n = 1; step();
      t_reset(); t_codes(); t_priority(); t_fifo(); t_enh(); t_xoff(); t_thre(); t_freeze();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule